// File: doc/BRIEF.md
# Chip-Select Activity Watchdog with Supply Reset

This supervisor drives a system reset from two sources. The first is a supply-good input from an external comparator. While that input is low, reset is asserted at once. When the supply recovers, reset is held for a further fixed hold time before it releases. The second source is a watchdog. It is restarted only by a falling edge of a chip-select line. If that line stays high, or stays low, for longer than the selected timeout, the watchdog fires a reset pulse.

All intervals are counted in system clocks. The parameter `CLKS_PER_MS` sets how many clocks make one millisecond, so simulation can run on a short scale. The chip-select line passes through a two-flop synchronizer before its falling edge is detected. Reset is offered in both polarities.

Top module: `cs_watchdog_supervisor`

## Requirements
- R1: While `supply_ok_i` is low, `rst_o` is high in the same cycle, with no clock edge needed.
- R2: After `supply_ok_i` returns high, and after `rst_ni` is released, `rst_o` stays high for exactly HOLD = 200*CLKS_PER_MS clock edges, counting the first edge that sees the supply good. It then goes low.
- R3: With the watchdog armed and `cs_i` held high, reset fires once the timeout passes without a falling edge.
- R4: With the watchdog armed and `cs_i` held low after a falling edge, reset fires exactly LIMIT+3 edges after the falling edge is driven. This allows two synchronizer stages and one clear edge.
- R5: Each falling edge of `cs_i` restarts the watchdog count. Falling edges spaced closer than the timeout keep reset low indefinitely.
- R6: `wd_sel_i` chooses the timeout LIMIT = ms*CLKS_PER_MS. The encodings are 2'b00 = 200 ms, 2'b01 = 600 ms, 2'b10 = 1400 ms and 2'b11 = watchdog off.
- R7: A watchdog reset pulse lasts exactly HOLD edges. The count then restarts from zero, so with no falling edge the next pulse fires LIMIT edges after release.
- R8: The watchdog does not count while reset is asserted. After a supply reset with `cs_i` idle, the first watchdog pulse fires LIMIT edges after reset releases.
- R9: `wd_enable_i` low disables the watchdog whatever the value of `wd_sel_i`.
- R10: `rst_no` is always the complement of `rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low logic reset |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator |
| wd_enable_i | input | 1 | Watchdog master enable |
| wd_sel_i | input | 2 | Timeout select (00 = 200 ms, 01 = 600 ms, 10 = 1400 ms, 11 = off) |
| cs_i | input | 1 | Chip-select line watched for falling edges |
| rst_o | output | 1 | Active-high system reset |
| rst_no | output | 1 | Active-low system reset |

## Verification
A supply drop must show on `rst_o` one time step after it is driven, before any clock edge. A supply recovery releases reset after exactly HOLD edges. A chip-select fall restarts the count on the third edge, and a missing refresh fires on edge LIMIT+3. Each directed task drives its stimulus just after a falling clock edge and counts rising edges from there. It samples once one edge before the expected change and once at the edge itself, so an error of one cycle in either direction is caught. Pulse length and the gap to the next pulse are measured the same way, counting from the edge that fired.

// File: rtl/cs_wd_pkg.sv
package cs_wd_pkg;
  typedef enum logic [1:0] {
    WD_T200  = 2'b00,
    WD_T600  = 2'b01,
    WD_T1400 = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  localparam int unsigned HOLD_MS = 200;

  function automatic int unsigned sel_to_ms(wd_sel_e sel);
    case (sel)
      WD_T200:  return 200;
      WD_T600:  return 600;
      WD_T1400: return 1400;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/cs_fall_detect.sv
module cs_fall_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  output logic fall_o
);
  logic cs_meta, cs_sync, cs_last;

  // idle-high reset value avoids a false edge at startup
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_meta <= 1'b1;
      cs_sync <= 1'b1;
      cs_last <= 1'b1;
    end else begin
      cs_meta <= cs_i;
      cs_sync <= cs_meta;
      cs_last <= cs_sync;
    end
  end

  assign fall_o = cs_last & ~cs_sync;

  a_r5_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned HOLD_CLKS = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(HOLD_CLKS + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CLKS);

  logic [CW-1:0] cnt_q;

  // power-on: start loaded so reset is held after rst_ni release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= HOLD_V;
    else if (load_i)      cnt_q <= HOLD_V;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  a_r2_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r2_load_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == HOLD_V));
endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
  parameter int unsigned CW = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          armed_i,
  input  logic          hold_i,
  input  logic          clear_i,
  input  logic [CW-1:0] limit_i,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q;
  logic          run;

  assign run    = armed_i && !hold_i && !clear_i;
  assign fire_o = run && (cnt_q >= limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (fire_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r5_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
  a_r8_frozen_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
  a_r9_disarmed_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> !fire_o);
endmodule

// File: rtl/cs_watchdog_supervisor.sv
module cs_watchdog_supervisor
  import cs_wd_pkg::*;
#(
  parameter int unsigned CLKS_PER_MS = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       supply_ok_i,
  input  logic       wd_enable_i,
  input  logic [1:0] wd_sel_i,
  input  logic       cs_i,
  output logic       rst_o,
  output logic       rst_no
);
  localparam int unsigned HOLD_CLKS = HOLD_MS * CLKS_PER_MS;
  localparam int unsigned MAX_LIMIT = 1400 * CLKS_PER_MS;
  localparam int unsigned CW        = $clog2(MAX_LIMIT + 1);

  wd_sel_e       sel;
  logic          cs_fall;
  logic          hold_active;
  logic          in_reset;
  logic          wd_fire;
  logic          wd_armed;
  logic [CW-1:0] wd_limit;

  assign sel      = wd_sel_e'(wd_sel_i);
  assign wd_armed = wd_enable_i && (sel != WD_OFF);
  assign wd_limit = CW'(sel_to_ms(sel) * CLKS_PER_MS);

  cs_fall_detect u_cs_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_i   (cs_i),
    .fall_o (cs_fall)
  );

  hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (!supply_ok_i || wd_fire),
    .active_o (hold_active)
  );

  wd_counter #(.CW(CW)) u_wd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (wd_armed),
    .hold_i  (in_reset),
    .clear_i (cs_fall),
    .limit_i (wd_limit),
    .fire_o  (wd_fire)
  );

  // supply loss bypasses the register for immediate assertion
  assign in_reset = !supply_ok_i || hold_active;
  assign rst_o    = in_reset;
  assign rst_no   = ~in_reset;

  a_r2_supply_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> rst_o);
  a_r7_fire_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_fire |=> rst_o);
  a_r8_no_fire_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> !wd_fire);
  a_r10_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_no != rst_o);
endmodule

// File: tb/cs_watchdog_supervisor_bench.sv
module cs_watchdog_supervisor_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int CLKS_PER_MS = 4;
  localparam int HOLD        = 200 * CLKS_PER_MS;
  localparam int L200        = 200 * CLKS_PER_MS;
  localparam int L600        = 600 * CLKS_PER_MS;
  localparam int L1400       = 1400 * CLKS_PER_MS;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       supply_ok = 1'b1;
  logic       wd_enable = 1'b1;
  logic [1:0] wd_sel = 2'b00;
  logic       cs = 1'b1;
  logic       rst_o, rst_no;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_watchdog_supervisor #(.CLKS_PER_MS(CLKS_PER_MS)) u_cs_watchdog_supervisor (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok),
    .wd_enable_i (wd_enable),
    .wd_sel_i    (wd_sel),
    .cs_i        (cs),
    .rst_o       (rst_o),
    .rst_no      (rst_no)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_rst(input bit exp, input string req);
    check(rst_o == exp, req, rst_o, exp);
    check(rst_no == !exp, "R10", rst_no, !exp);
  endtask

  // leave reset, then refresh so the count is near zero
  task automatic settle();
    int guard = 0;
    while (rst_o && guard < 4 * HOLD) begin
      edges(1);
      guard++;
    end
    cs = 1'b1; edges(3);
    cs = 1'b0; edges(3);
  endtask

  // drive a fall now, hold CS low, expect pulse on edge limit+3
  task automatic fall_and_time(input int limit, input string req);
    cs = 1'b1; edges(3);
    cs = 1'b0;
    edges(limit + 2);
    expect_rst(1'b0, req);
    edges(1);
    expect_rst(1'b1, req);
  endtask

  task automatic t_power_on();
    @(negedge clk);
    rst_ni = 1'b1;
    expect_rst(1'b1, "R2");
    edges(HOLD - 1);
    expect_rst(1'b1, "R2");
    edges(1);
    expect_rst(1'b0, "R2");
  endtask

  task automatic t_brownout_stuck_high();
    cs = 1'b1;
    @(negedge clk);
    supply_ok = 1'b0;
    #1;
    check(rst_o == 1'b1, "R1", rst_o, 1);
    check(rst_no == 1'b0, "R10", rst_no, 0);
    edges(L200 + 200);      // longer than a timeout: must not count
    expect_rst(1'b1, "R1");
    supply_ok = 1'b1;
    edges(HOLD - 1);
    expect_rst(1'b1, "R2");
    edges(1);
    expect_rst(1'b0, "R2");
    // R8, R3: CS idle high, first pulse LIMIT edges after release
    edges(L200 - 1);
    expect_rst(1'b0, "R8");
    edges(1);
    expect_rst(1'b1, "R3");
    // R7: pulse length, then count restarts
    edges(HOLD - 1);
    expect_rst(1'b1, "R7");
    edges(1);
    expect_rst(1'b0, "R7");
    edges(L200 - 1);
    expect_rst(1'b0, "R7");
    edges(1);
    expect_rst(1'b1, "R7");
  endtask

  task automatic t_refresh();
    int bad = 0;
    settle();
    for (int p = 0; p < 8; p++) begin
      cs = 1'b1; edges(L200 / 4);
      if (rst_o) bad++;
      cs = 1'b0; edges(L200 / 4);
      if (rst_o) bad++;
    end
    check(bad == 0, "R5", bad, 0);
    expect_rst(1'b0, "R5");
  endtask

  task automatic t_stuck_low();
    settle();
    fall_and_time(L200, "R4");
  endtask

  task automatic t_select_600();
    wd_sel = 2'b01;
    settle();
    fall_and_time(L600, "R6");
  endtask

  task automatic t_select_1400();
    wd_sel = 2'b10;
    settle();
    fall_and_time(L1400, "R6");
  endtask

  task automatic t_disabled();
    int hits = 0;
    wd_sel = 2'b11;
    settle();
    for (int i = 0; i < L1400 + 400; i++) begin
      edges(1);
      if (rst_o) hits++;
    end
    check(hits == 0, "R6", hits, 0);
    wd_sel = 2'b00;
    wd_enable = 1'b0;
    hits = 0;
    for (int i = 0; i < L200 + 400; i++) begin
      edges(1);
      if (rst_o) hits++;
    end
    check(hits == 0, "R9", hits, 0);
    wd_enable = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_power_on();
    t_brownout_stuck_high();
    t_refresh();
    t_stuck_low();
    t_select_600();
    t_select_1400();
    t_disabled();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule